// File: doc/BRIEF.md
# Serial Bit-Stuffing Inserter and Remover

This block holds the two ends of a stuffing scheme for an NRZ serial link whose receiver recovers timing from level changes. On the send side, a source offers one data bit at a time through a valid/ready handshake. The inserter emits each accepted bit as a line level, one symbol per enabled bit slot. When a fixed number of symbols in a row (three by default) have kept the same level as the symbol before them, the inserter spends the next slot on an extra symbol of the opposite level. It withholds ready from the source during that slot. The extra symbol is sent every time, even when the following data bit would have changed the level on its own. Without that rule the receiver could not tell a stuffed symbol from a real one.

On the receive side, the remover is given each incoming symbol with a strobe. It counts runs with the same rule, recognises the slot that must carry a stuffed symbol and discards it. It passes on only data bits, each with a one-cycle valid pulse. If a symbol in a stuff slot does not change level, the remover flags a one-cycle error, drops that symbol and starts counting afresh. After reset both ends take the previous line level as high and the run count as zero. The two ends share nothing but the run rule, so they can sit in different clock domains or on different chips.

Top module: `bit_stuff_link`

## Requirements
- R1: After reset `line_out` is 1, `tx_ready` is 1, and `line_strobe`, `rx_data_valid` and `stuff_error` are 0.
- R2: When `bit_en`, `tx_valid` and `tx_ready` are all 1 at a clock edge, the inserter drives `tx_data` on `line_out` after that edge and pulses `line_strobe` for one cycle.
- R3: After RUN_LEN (default 3) consecutive emitted symbols that each equal the symbol before them, the next emitted symbol is a stuff symbol equal to the inverse of the last level. The reset level 1 counts as the symbol before the first one.
- R4: The stuff symbol is emitted even when the next data bit differs from the current line level.
- R5: After the symbol that completes the run, `tx_ready` is 0 until the stuff symbol has been emitted, which is exactly one enabled bit slot. No data is accepted during that slot.
- R6: The run count restarts from zero after every level change, including the change made by a stuff symbol.
- R7: In a cycle with `bit_en` low, or with `tx_valid` low and no stuff pending, no symbol is emitted: `line_strobe` stays 0 and `line_out` holds its level.
- R8: For each `rx_sym_strobe` in a data slot, `rx_data` carries `rx_sym` after the next edge with a one-cycle `rx_data_valid`. A correctly toggling symbol in a stuff slot produces no output and no error.
- R9: A symbol in a stuff slot that keeps the previous level raises `stuff_error` for one cycle with no `rx_data_valid`. The remover's run count then restarts, so the next symbol is treated as data.
- R10: With `line_out`/`line_strobe` fed to `rx_sym`/`rx_sym_strobe`, the remover reproduces the accepted data bit sequence exactly, in order, and never raises `stuff_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Send-side bit-slot enable, one symbol at most per enabled cycle |
| tx_valid | input | 1 | Source offers a data bit |
| tx_data | input | 1 | Offered data bit |
| tx_ready | output | 1 | Inserter can take a data bit in this slot |
| line_out | output | 1 | Current line level |
| line_strobe | output | 1 | One-cycle pulse when a new symbol is placed on `line_out` |
| rx_sym | input | 1 | Incoming symbol level |
| rx_sym_strobe | input | 1 | Incoming symbol is present this cycle |
| rx_data | output | 1 | Recovered data bit |
| rx_data_valid | output | 1 | One-cycle pulse marking `rx_data` |
| stuff_error | output | 1 | One-cycle pulse for a non-toggling symbol in a stuff slot |

## Verification
The assertions check on every cycle properties that follow from the ports alone. A shadow run count on the line output must never let RUN_LEN+1 unchanged symbols pass in a row. Ready must fall right after the symbol that completes a run and must come back after one enabled slot. A symbol may appear only in an enabled slot, and the line may change only together with a strobe. On the receive side, output and error pulses may appear only after an incoming strobe and never together. The bench scenarios cover what those properties cannot. They check that the data bits survive the inserter and remover unchanged across every 10-bit pattern, with gaps in both the enable and the valid signal. They check the exact placement of each stuff symbol, and they check that a stuff slot which fails to toggle drops the symbol and restarts the count.

// File: rtl/bs_pkg.sv
package bs_pkg;

   // Kind of the bit slot currently being handled by either stage.
   typedef enum logic {
      SLOT_DATA  = 1'b0,
      SLOT_STUFF = 1'b1
   } slot_kind_e;

   // Width of a counter that must hold values 0 .. limit-1.
   function automatic int unsigned run_cnt_width(input int unsigned limit);
      return (limit <= 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/bs_run_tracker.sv
// Counts consecutive symbols that repeat the previous level and reports the
// step that completes a run of RUN_LEN such symbols.
module bs_run_tracker #(
   parameter int unsigned RUN_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,   // a symbol is handled this cycle
   input  logic same_i,   // the symbol repeats the previous level (0 forces a restart)
   output logic hit_o     // this symbol completes the run
);

   generate
      if (RUN_LEN == 1) begin : g_direct
         // Every repeat completes a run; no storage needed.
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign hit_o = step_i && same_i;
      end else begin : g_count
         localparam int unsigned CW = bs_pkg::run_cnt_width(RUN_LEN);
         localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

         logic [CW-1:0] cnt_q;

         assign hit_o = step_i && same_i && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (step_i) begin
               if (same_i && !hit_o) begin
                  cnt_q <= cnt_q + 1'b1;
               end else begin
                  cnt_q <= '0;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bs_tx_stuffer.sv
// Send side: emits accepted data bits as NRZ levels and forces a level change
// after every run of repeated symbols.
module bs_tx_stuffer
   import bs_pkg::*;
#(
   parameter int unsigned RUN_LEN    = 3,
   parameter logic        IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en_i,
   input  logic valid_i,
   input  logic data_i,
   output logic ready_o,
   output logic line_o,
   output logic strobe_o
);

   logic       pend_q;
   logic       line_q;
   logic       strb_q;
   slot_kind_e kind;
   logic       step;
   logic       same;
   logic       nxt_level;
   logic       hit;

   assign kind      = pend_q ? SLOT_STUFF : SLOT_DATA;
   assign step      = bit_en_i && (pend_q || valid_i);
   assign nxt_level = (kind == SLOT_STUFF) ? ~line_q : data_i;
   assign same      = (kind == SLOT_DATA) && (data_i == line_q);

   bs_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .same_i (same),
      .hit_o  (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         line_q <= IDLE_LEVEL;
         strb_q <= 1'b0;
      end else begin
         strb_q <= step;
         if (step) begin
            line_q <= nxt_level;
            pend_q <= hit;
         end
      end
   end

   assign ready_o  = !pend_q;
   assign line_o   = line_q;
   assign strobe_o = strb_q;

endmodule

// File: rtl/bs_rx_destuffer.sv
// Receive side: applies the same run rule, drops stuff symbols and flags a
// stuff slot whose symbol kept the previous level.
module bs_rx_destuffer
   import bs_pkg::*;
#(
   parameter int unsigned RUN_LEN    = 3,
   parameter logic        IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sym_i,
   input  logic strobe_i,
   output logic data_o,
   output logic valid_o,
   output logic err_o
);

   logic       expect_q;
   logic       prev_q;
   logic       data_q;
   logic       valid_q;
   logic       err_q;
   slot_kind_e kind;
   logic       repeat_lvl;
   logic       same;
   logic       hit;

   assign kind       = expect_q ? SLOT_STUFF : SLOT_DATA;
   assign repeat_lvl = (sym_i == prev_q);
   assign same       = (kind == SLOT_DATA) && repeat_lvl;

   bs_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (strobe_i),
      .same_i (same),
      .hit_o  (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expect_q <= 1'b0;
         prev_q   <= IDLE_LEVEL;
         data_q   <= 1'b0;
         valid_q  <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         valid_q <= strobe_i && (kind == SLOT_DATA);
         err_q   <= strobe_i && (kind == SLOT_STUFF) && repeat_lvl;
         if (strobe_i) begin
            prev_q   <= sym_i;
            expect_q <= hit;
            if (kind == SLOT_DATA) begin
               data_q <= sym_i;
            end
         end
      end
   end

   assign data_o  = data_q;
   assign valid_o = valid_q;
   assign err_o   = err_q;

endmodule

// File: rtl/bit_stuff_link.sv
// Top: send-side inserter and receive-side remover sharing one run rule.
module bit_stuff_link #(
   parameter int unsigned RUN_LEN    = 3,
   parameter logic        IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic tx_valid,
   input  logic tx_data,
   output logic tx_ready,
   output logic line_out,
   output logic line_strobe,
   input  logic rx_sym,
   input  logic rx_sym_strobe,
   output logic rx_data,
   output logic rx_data_valid,
   output logic stuff_error
);

   generate
      if (RUN_LEN < 1 || RUN_LEN > 255) begin : g_bad_run_len
         $error("bit_stuff_link: RUN_LEN must lie in 1..255");
      end
   endgenerate

   bs_tx_stuffer #(
      .RUN_LEN    (RUN_LEN),
      .IDLE_LEVEL (IDLE_LEVEL)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en_i (bit_en),
      .valid_i  (tx_valid),
      .data_i   (tx_data),
      .ready_o  (tx_ready),
      .line_o   (line_out),
      .strobe_o (line_strobe)
   );

   bs_rx_destuffer #(
      .RUN_LEN    (RUN_LEN),
      .IDLE_LEVEL (IDLE_LEVEL)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym_i    (rx_sym),
      .strobe_i (rx_sym_strobe),
      .data_o   (rx_data),
      .valid_o  (rx_data_valid),
      .err_o    (stuff_error)
   );

endmodule

// File: rtl/bs_link_checker.sv
module bs_link_checker #(
   parameter int unsigned RUN_LEN    = 3,
   parameter logic        IDLE_LEVEL = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic tx_valid,
   input logic tx_ready,
   input logic line_out,
   input logic line_strobe,
   input logic rx_sym_strobe,
   input logic rx_data_valid,
   input logic stuff_error
);

   // Shadow run count built only from the line output.
   logic        chk_prev;
   int unsigned chk_run;
   logic        chk_same;

   assign chk_same = (line_out == chk_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_prev <= IDLE_LEVEL;
         chk_run  <= 0;
      end else if (line_strobe) begin
         chk_prev <= line_out;
         chk_run  <= chk_same ? chk_run + 1 : 0;
      end
   end

   // R3: never more than RUN_LEN repeated symbols in a row
   a_r3_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (line_strobe && chk_same) |-> (chk_run < RUN_LEN));

   // R5: ready falls as soon as a run is complete
   a_r5_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (line_strobe && chk_same && chk_run == RUN_LEN - 1) |-> !tx_ready);

   // R5: ready is withheld for one enabled slot only
   a_r5_ready_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !tx_ready) |=> tx_ready);

   // R7: symbols only in enabled slots
   a_r7_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      line_strobe |-> $past(bit_en));

   // R7: line level changes only with a strobe
   a_r7_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !line_strobe |-> $stable(line_out));

   // R8: output only after an incoming symbol
   a_r8_out_after_sym: assert property (@(posedge clk) disable iff (!rst_n)
      rx_data_valid |-> $past(rx_sym_strobe));

   // R9: an error drops the symbol and follows an incoming symbol
   a_r9_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_error |-> (!rx_data_valid && $past(rx_sym_strobe)));

   logic unused_valid;
   assign unused_valid = tx_valid;

endmodule

bind bit_stuff_link bs_link_checker #(
   .RUN_LEN    (RUN_LEN),
   .IDLE_LEVEL (IDLE_LEVEL)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bit_en        (bit_en),
   .tx_valid      (tx_valid),
   .tx_ready      (tx_ready),
   .line_out      (line_out),
   .line_strobe   (line_strobe),
   .rx_sym_strobe (rx_sym_strobe),
   .rx_data_valid (rx_data_valid),
   .stuff_error   (stuff_error)
);

// File: tb/bit_stuff_link_tb.sv
module bit_stuff_link_tb;

   localparam int CLK_PERIOD = 10;
   localparam int RUNL       = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0;
   logic tx_valid = 1'b0;
   logic tx_data = 1'b0;
   logic tx_ready, line_out, line_strobe;
   logic rx_data, rx_data_valid, stuff_error;
   logic loop_mode = 1'b1;
   logic inj_sym = 1'b0;
   logic inj_stb = 1'b0;
   logic rx_sym_w, rx_stb_w;

   int errors = 0;
   int checks = 0;

   assign rx_sym_w = loop_mode ? line_out    : inj_sym;
   assign rx_stb_w = loop_mode ? line_strobe : inj_stb;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bit_stuff_link #(.RUN_LEN(RUNL), .IDLE_LEVEL(1'b1)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bit_en        (bit_en),
      .tx_valid      (tx_valid),
      .tx_data       (tx_data),
      .tx_ready      (tx_ready),
      .line_out      (line_out),
      .line_strobe   (line_strobe),
      .rx_sym        (rx_sym_w),
      .rx_sym_strobe (rx_stb_w),
      .rx_data       (rx_data),
      .rx_data_valid (rx_data_valid),
      .stuff_error   (stuff_error)
   );

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // Accepted data bits, in order
   logic expq [0:16383];
   int   wr = 0;
   int   rk = 0;

   // Monitor model, built from the requirements
   logic m_prev = 1'b1;
   int   m_run = 0;
   logic m_pend = 1'b0;
   int   m_k = 0;
   logic m_after_stuff = 1'b0;

   always @(negedge clk) begin
      if (rst_n && loop_mode) begin
         logic exp_stb;
         logic exp_lvl;
         exp_stb = bit_en && (tx_valid || m_pend);
         check("R7 symbol only in an active slot", int'(line_strobe), int'(exp_stb));
         if (line_strobe) begin
            if (m_pend) begin
               exp_lvl = ~m_prev;
               check("R3 R4 forced stuff symbol", int'(line_out), int'(exp_lvl));
               m_pend = 1'b0;
               m_run = 0;
               m_after_stuff = 1'b1;
            end else begin
               exp_lvl = expq[m_k];
               m_k++;
               if (m_after_stuff)
                  check("R6 data after stuff", int'(line_out), int'(exp_lvl));
               else
                  check("R2 data symbol", int'(line_out), int'(exp_lvl));
               m_after_stuff = 1'b0;
               if (exp_lvl == m_prev) begin
                  m_run++;
                  if (m_run == RUNL) begin
                     m_pend = 1'b1;
                     m_run = 0;
                  end
               end else begin
                  m_run = 0;
               end
            end
            m_prev = exp_lvl;
            check("R5 ready reflects pending stuff", int'(tx_ready), int'(!m_pend));
         end else begin
            check("R7 line holds", int'(line_out), int'(m_prev));
         end
         if (rx_data_valid) begin
            check("R10 recovered bit", int'(rx_data), int'(expq[rk]));
            rk++;
         end
         check("R10 no error in loopback", int'(stuff_error), 0);
      end
   end

   task automatic send_bit(input logic b, input int mode);
      bit done;
      int cyc;
      done = 1'b0;
      cyc = 0;
      while (!done) begin
         @(negedge clk);
         #1;
         cyc++;
         bit_en   = (mode == 0) ? 1'b1 : ((cyc % 4) != 3);
         tx_valid = (mode == 2) ? ((cyc % 3) != 1) : 1'b1;
         tx_data  = b;
         if (bit_en && tx_valid && tx_ready) begin
            expq[wr] = b;
            wr++;
            done = 1'b1;
         end
      end
   endtask

   task automatic rx_send(input logic lvl, input int e_valid, input int e_data,
                          input int e_err, input string tag);
      @(negedge clk);
      #1;
      inj_sym = lvl;
      inj_stb = 1'b1;
      @(negedge clk);
      check({tag, " valid"}, int'(rx_data_valid), e_valid);
      if (e_valid != 0) check({tag, " data"}, int'(rx_data), e_data);
      check({tag, " error"}, int'(stuff_error), e_err);
      #1;
      inj_stb = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset line level", int'(line_out), 1);
      check("R1 reset ready", int'(tx_ready), 1);
      check("R1 reset strobe", int'(line_strobe), 0);
      check("R1 reset rx valid", int'(rx_data_valid), 0);
      check("R1 reset error", int'(stuff_error), 0);
      #1;
      rst_n = 1'b1;

      // R4 directed: 1,1,1 then 0 -> stuff 0 must still precede the data 0
      send_bit(1'b1, 0);
      send_bit(1'b1, 0);
      send_bit(1'b1, 0);
      send_bit(1'b0, 0);

      // Sweep of every 10-bit pattern under three slot patterns
      for (int v = 0; v < 1024; v++) begin
         for (int b = 0; b < 10; b++) begin
            send_bit(v[b] ? 1'b1 : 1'b0, v % 3);
         end
      end

      // Flush: enable slots with no data so a pending stuff goes out
      @(negedge clk);
      #1;
      tx_valid = 1'b0;
      bit_en   = 1'b1;
      repeat (4) @(negedge clk);
      #1;
      bit_en = 1'b0;
      repeat (4) @(negedge clk);
      check("R10 recovered count", rk, wr);

      // Direct receive-side scenarios
      #1;
      loop_mode = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      #1;
      rst_n = 1'b1;
      rx_send(1'b1, 1, 1, 0, "R8 run 1");
      rx_send(1'b1, 1, 1, 0, "R8 run 2");
      rx_send(1'b1, 1, 1, 0, "R8 run 3");
      rx_send(1'b1, 0, 0, 1, "R9 non-toggling stuff slot");
      rx_send(1'b0, 1, 0, 0, "R9 count restarted");
      rx_send(1'b0, 1, 0, 0, "R8 run 1b");
      rx_send(1'b0, 1, 0, 0, "R8 run 2b");
      rx_send(1'b0, 1, 0, 0, "R8 run 3b");
      rx_send(1'b1, 0, 0, 0, "R8 stuff dropped");
      rx_send(1'b1, 1, 1, 0, "R8 data after stuff");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule